// File: doc/BRIEF.md
# Multi-bank DRAM channel request scheduler

This block is an in-order issue controller for one DRAM channel that holds several independent banks. Read and write requests arrive on a valid/ready port, each carrying a bank index and a request ID. Every request passes through three shared resources, always in the same order: one cycle on the address bus, a bank access window on its target bank, then a transfer on the data bus. A read's transfer is longer than a write's.

A request is accepted only when its complete schedule can be reserved at fixed offsets from the accept cycle. The schedule must not collide with any earlier reservation. The block keeps a countdown per resource for this, plus the direction of the last transfer. Requests to different banks overlap their bank windows. A transfer that changes direction can be forced to leave one idle cycle on the data bus. The block pulses an event at the start of each phase and on the last cycle of each transfer, each event tagged with the request ID. A request that cannot be reserved is held at the port with ready low until it fits.

Top module: `dram_chan_sched`

## Requirements
- R1: A request is accepted in the cycle where `req_valid_i` and `req_ready_o` are both high. In that same cycle `addr_start_o` pulses with `addr_id_o` equal to the request ID. `req_ready_o` does not depend on `req_valid_i`.
- R2: `bank_start_o` pulses exactly 1 cycle after acceptance, with `bank_id_o` equal to the request ID.
- R3: For a read (`req_wr_i`=0), `data_start_o` pulses 10 cycles after acceptance with `data_wr_o`=0. `done_o` pulses 16 cycles after acceptance (the 7th transfer cycle) with `done_wr_o`=0 and the request ID.
- R4: For a write (`req_wr_i`=1), `data_start_o` pulses 10 cycles after acceptance with `data_wr_o`=1. `done_o` pulses 13 cycles after acceptance (the 4th transfer cycle) with `done_wr_o`=1.
- R5: Each bank's window lasts 9 cycles, and windows on one bank never overlap. A request to the same bank as the previous one is accepted no earlier than 9 cycles after it.
- R6: Transfers never overlap on the data bus. Between requests to different banks in the same direction, the earliest acceptance gap equals the earlier transfer's length: 7 after a read, 4 after a write.
- R7: With `TURN_CYC`=1, a transfer whose direction differs from the previous transfer starts at least 1 idle cycle after that transfer ends. The read-to-write gap is therefore 8 and the write-to-read gap 5. The first transfer after reset pays no such penalty.
- R8: A request that cannot be reserved is held with `req_ready_o` low and is accepted only once. Requests complete in acceptance order.
- R9: After reset every resource is free. `req_ready_o` is high and no event output pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request's full schedule can be reserved now |
| req_wr_i | input | 1 | 1 = write, 0 = read |
| req_bank_i | input | BANK_W | Target bank |
| req_id_i | input | ID_W | Request tag |
| addr_start_o | output | 1 | Address phase starts (acceptance cycle) |
| addr_id_o | output | ID_W | Tag of the address phase |
| bank_start_o | output | 1 | Bank window starts |
| bank_id_o | output | ID_W | Tag of the bank window |
| data_start_o | output | 1 | Data transfer starts |
| data_id_o | output | ID_W | Tag of the transfer |
| data_wr_o | output | 1 | Direction of the starting transfer |
| done_o | output | 1 | Last transfer cycle of a request |
| done_id_o | output | ID_W | Tag of the completing request |
| done_wr_o | output | 1 | Direction of the completing request |

## Verification
The hardest situation to reach is two transfers that sit back to back on the data bus while switching direction. Only there does the one idle turnaround cycle show, as a gap of 5 instead of 4 or 8 instead of 7. To reach it, the bench presents the second request in the cycle right after the first is accepted and holds it until `req_ready_o` rises. The measured acceptance gap then equals the earliest legal one. The same back-to-back method separates the bank-bound gap from the data-bus-bound gap.

// File: rtl/dram_sched_pkg.sv
package dram_sched_pkg;

  typedef enum logic {
    DIR_RD = 1'b0,
    DIR_WR = 1'b1
  } dir_e;

  function automatic int unsigned xfer_len(input logic wr, input int unsigned rd_cyc,
                                           input int unsigned wr_cyc);
    return (wr == DIR_WR) ? wr_cyc : rd_cyc;
  endfunction

endpackage

// File: rtl/sched_bank_track.sv
module sched_bank_track #(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned BANK_W    = 2,
  parameter int unsigned CNT_W     = 5,
  parameter int unsigned ADDR_CYC  = 1,
  parameter int unsigned BANK_CYC  = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic [BANK_W-1:0] bank_i,
  output logic              bank_free_o
);

  // cycles until each bank may open a new window
  logic [CNT_W-1:0] rem_q [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rem_q[b] <= '0;
      end else if (issue_i && (bank_i == BANK_W'(b))) begin
        rem_q[b] <= CNT_W'(ADDR_CYC + BANK_CYC - 1);
      end else if (rem_q[b] != '0) begin
        rem_q[b] <= rem_q[b] - 1'b1;
      end
    end
  end

  // bank window opens ADDR_CYC cycles after issue
  assign bank_free_o = rem_q[bank_i] <= CNT_W'(ADDR_CYC);

endmodule

// File: rtl/sched_data_track.sv
module sched_data_track
  import dram_sched_pkg::*;
#(
  parameter int unsigned CNT_W    = 5,
  parameter int unsigned LAT      = 10,
  parameter int unsigned RD_CYC   = 7,
  parameter int unsigned WR_CYC   = 4,
  parameter int unsigned TURN_CYC = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic issue_i,
  input  logic wr_i,
  output logic fits_o
);

  logic [CNT_W-1:0] rem_q;
  logic             last_wr_q;
  logic             used_q;
  logic [CNT_W:0]   need;

  always_comb begin
    need = {1'b0, rem_q};
    if (used_q && (last_wr_q != wr_i)) need = need + (CNT_W+1)'(TURN_CYC);
  end

  // transfer would start LAT cycles after issue
  assign fits_o = need <= (CNT_W+1)'(LAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q     <= '0;
      last_wr_q <= 1'b0;
      used_q    <= 1'b0;
    end else if (issue_i) begin
      rem_q     <= CNT_W'(LAT + xfer_len(wr_i, RD_CYC, WR_CYC) - 1);
      last_wr_q <= wr_i;
      used_q    <= 1'b1;
    end else if (rem_q != '0) begin
      rem_q <= rem_q - 1'b1;
    end
  end

endmodule

// File: rtl/sched_event_pipe.sv
module sched_event_pipe
  import dram_sched_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned BANK_W    = 2,
  parameter int unsigned ID_W      = 4,
  parameter int unsigned ADDR_CYC  = 1,
  parameter int unsigned BANK_CYC  = 9,
  parameter int unsigned RD_CYC    = 7,
  parameter int unsigned WR_CYC    = 4,
  parameter int unsigned TURN_CYC  = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic              wr_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [ID_W-1:0]   id_i,
  output logic              bank_start_o,
  output logic [ID_W-1:0]   bank_id_o,
  output logic              data_start_o,
  output logic [ID_W-1:0]   data_id_o,
  output logic              data_wr_o,
  output logic              done_o,
  output logic [ID_W-1:0]   done_id_o,
  output logic              done_wr_o
);

  localparam int unsigned LAT    = ADDR_CYC + BANK_CYC;
  localparam int unsigned MAX_D  = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
  localparam int unsigned DEPTH  = LAT + MAX_D - 1;
  localparam int unsigned S_BANK = ADDR_CYC - 1;
  localparam int unsigned S_DATA = LAT - 1;
  localparam int unsigned S_RDON = LAT + RD_CYC - 2;
  localparam int unsigned S_WDON = LAT + WR_CYC - 2;

  // stage k holds the request issued k+1 cycles ago
  logic [DEPTH-1:0] vld_q;
  logic [DEPTH-1:0] wr_q;
  logic [ID_W-1:0]  id_q   [DEPTH];
  logic [BANK_W-1:0] bank_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      wr_q  <= '0;
      for (int k = 0; k < DEPTH; k++) begin
        id_q[k]   <= '0;
        bank_q[k] <= '0;
      end
    end else begin
      vld_q[0]  <= issue_i;
      wr_q[0]   <= wr_i;
      id_q[0]   <= id_i;
      bank_q[0] <= bank_i;
      for (int k = 1; k < DEPTH; k++) begin
        vld_q[k]  <= vld_q[k-1];
        wr_q[k]   <= wr_q[k-1];
        id_q[k]   <= id_q[k-1];
        bank_q[k] <= bank_q[k-1];
      end
    end
  end

  assign bank_start_o = vld_q[S_BANK];
  assign bank_id_o    = id_q[S_BANK];
  assign data_start_o = vld_q[S_DATA];
  assign data_id_o    = id_q[S_DATA];
  assign data_wr_o    = wr_q[S_DATA];

  logic rd_done, wr_done;
  assign rd_done   = vld_q[S_RDON] && (wr_q[S_RDON] == DIR_RD);
  assign wr_done   = vld_q[S_WDON] && (wr_q[S_WDON] == DIR_WR);
  assign done_o    = rd_done || wr_done;
  assign done_id_o = wr_done ? id_q[S_WDON] : id_q[S_RDON];
  assign done_wr_o = wr_done;

  // occupancy views for checking
  logic [DEPTH-1:0] in_data;
  logic [DEPTH-1:0] bank_hit [NUM_BANKS];

  for (genvar k = 0; k < DEPTH; k++) begin : g_stage
    localparam logic IN_RD = (k >= S_DATA) && (k <= S_RDON);
    localparam logic IN_WR = (k >= S_DATA) && (k <= S_WDON);
    localparam logic IN_BK = (k >= S_BANK) && (k <= S_BANK + BANK_CYC - 1);
    assign in_data[k] = vld_q[k] && (wr_q[k] ? IN_WR : IN_RD);
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bk
      assign bank_hit[b][k] = vld_q[k] && IN_BK && (bank_q[k] == BANK_W'(b));
    end
  end

  logic end_q, end_wr_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      end_q    <= 1'b0;
      end_wr_q <= 1'b0;
    end else begin
      end_q    <= done_o;
      end_wr_q <= done_wr_o;
    end
  end

  p_data_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(in_data) <= 1);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bchk
    p_bank_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(bank_hit[b]));
  end

  p_turn_gap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_start_o && end_q && (TURN_CYC != 0)) |-> (data_wr_o == end_wr_q));

endmodule

// File: rtl/dram_chan_sched.sv
module dram_chan_sched
  import dram_sched_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned ID_W      = 4,
  parameter int unsigned ADDR_CYC  = 1,
  parameter int unsigned BANK_CYC  = 9,
  parameter int unsigned RD_CYC    = 7,
  parameter int unsigned WR_CYC    = 4,
  parameter int unsigned TURN_CYC  = 1,
  localparam int unsigned BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_wr_i,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic [ID_W-1:0]   req_id_i,
  output logic              addr_start_o,
  output logic [ID_W-1:0]   addr_id_o,
  output logic              bank_start_o,
  output logic [ID_W-1:0]   bank_id_o,
  output logic              data_start_o,
  output logic [ID_W-1:0]   data_id_o,
  output logic              data_wr_o,
  output logic              done_o,
  output logic [ID_W-1:0]   done_id_o,
  output logic              done_wr_o
);

  localparam int unsigned LAT   = ADDR_CYC + BANK_CYC;
  localparam int unsigned MAX_D = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
  localparam int unsigned CNT_W = $clog2(LAT + MAX_D + TURN_CYC + 1);

  logic issue;
  logic addr_free, bank_free, data_fits;
  logic [CNT_W-1:0] addr_rem_q;

  assign addr_free   = addr_rem_q == '0;
  assign req_ready_o = addr_free && bank_free && data_fits;
  assign issue       = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_rem_q <= '0;
    end else if (issue) begin
      addr_rem_q <= CNT_W'(ADDR_CYC - 1);
    end else if (addr_rem_q != '0) begin
      addr_rem_q <= addr_rem_q - 1'b1;
    end
  end

  sched_bank_track #(
    .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .CNT_W(CNT_W),
    .ADDR_CYC(ADDR_CYC), .BANK_CYC(BANK_CYC)
  ) u_bank_track (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .issue_i    (issue),
    .bank_i     (req_bank_i),
    .bank_free_o(bank_free)
  );

  sched_data_track #(
    .CNT_W(CNT_W), .LAT(LAT), .RD_CYC(RD_CYC), .WR_CYC(WR_CYC), .TURN_CYC(TURN_CYC)
  ) u_data_track (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .issue_i(issue),
    .wr_i   (req_wr_i),
    .fits_o (data_fits)
  );

  sched_event_pipe #(
    .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .ID_W(ID_W), .ADDR_CYC(ADDR_CYC),
    .BANK_CYC(BANK_CYC), .RD_CYC(RD_CYC), .WR_CYC(WR_CYC), .TURN_CYC(TURN_CYC)
  ) u_event_pipe (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .issue_i     (issue),
    .wr_i        (req_wr_i),
    .bank_i      (req_bank_i),
    .id_i        (req_id_i),
    .bank_start_o(bank_start_o),
    .bank_id_o   (bank_id_o),
    .data_start_o(data_start_o),
    .data_id_o   (data_id_o),
    .data_wr_o   (data_wr_o),
    .done_o      (done_o),
    .done_id_o   (done_id_o),
    .done_wr_o   (done_wr_o)
  );

  assign addr_start_o = issue;
  assign addr_id_o    = req_id_i;

  p_same_bank_stall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue |=> !(issue && (req_bank_i == $past(req_bank_i))));

  p_addr_excl_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue && (ADDR_CYC > 1)) |=> !issue);

endmodule

// File: tb/dram_chan_sched_bench.sv
module dram_chan_sched_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_wr = 1'b0;
  logic [1:0] req_bank = '0;
  logic [3:0] req_id = '0;
  logic       req_ready;
  logic       addr_start, bank_start, data_start, data_wr, done, done_wr;
  logic [3:0] addr_id, bank_id, data_id, done_id;

  always #2 clk = ~clk;

  dram_chan_sched #(.NUM_BANKS(4), .ID_W(4), .TURN_CYC(1)) u_dram_chan_sched (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_wr_i(req_wr),
    .req_bank_i(req_bank), .req_id_i(req_id),
    .addr_start_o(addr_start), .addr_id_o(addr_id),
    .bank_start_o(bank_start), .bank_id_o(bank_id),
    .data_start_o(data_start), .data_id_o(data_id), .data_wr_o(data_wr),
    .done_o(done), .done_id_o(done_id), .done_wr_o(done_wr)
  );

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  int addr_cnt = 0;
  int done_cnt = 0;
  bit finished = 0;
  int ev_addr [16];
  int ev_bank [16];
  int ev_data [16];
  int ev_done [16];
  int ev_ord  [16];
  bit ev_dwr  [16];
  bit ev_fwr  [16];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    #1.5;
    if (rst_n) begin
      if (addr_start) begin ev_addr[addr_id] = cyc; addr_cnt++; end
      if (bank_start) ev_bank[bank_id] = cyc;
      if (data_start) begin ev_data[data_id] = cyc; ev_dwr[data_id] = data_wr; end
      if (done) begin
        ev_done[done_id] = cyc; ev_fwr[done_id] = done_wr;
        ev_ord[done_id] = done_cnt; done_cnt++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input int b, input bit w, input int id, output int at);
    req_valid = 1'b1; req_bank = 2'(b); req_wr = w; req_id = 4'(id);
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    at = cyc;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic drain();
    repeat (30) @(negedge clk);
  endtask

  task automatic pair(input int b1, input bit w1, input int i1,
                      input int b2, input bit w2, input int i2,
                      input int gap, input string req);
    int n1, n2, a0;
    a0 = addr_cnt;
    @(negedge clk);
    send(b1, w1, i1, n1);
    @(negedge clk);
    send(b2, w2, i2, n2);
    drain();
    check(n2 - n1 == gap, req, n2 - n1, gap);
    check(ev_ord[i1] < ev_ord[i2], "R8 order", ev_ord[i1], ev_ord[i2]);
    check(addr_cnt - a0 == 2, "R8 single accept", addr_cnt - a0, 2);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    req_wr = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    check(req_ready == 1'b1, "R9 ready", int'(req_ready), 1);
    check(!done && !data_start && !bank_start, "R9 idle",
          int'({done, data_start, bank_start}), 0);
  endtask

  task automatic t_read();
    int n;
    @(negedge clk);
    send(0, 1'b0, 1, n);
    drain();
    check(ev_addr[1] == n, "R1 addr", ev_addr[1], n);
    check(ev_bank[1] == n + 1, "R2 bank", ev_bank[1], n + 1);
    check(ev_data[1] == n + 10 && ev_dwr[1] == 1'b0, "R3 data", ev_data[1], n + 10);
    check(ev_done[1] == n + 16 && ev_fwr[1] == 1'b0, "R3 done", ev_done[1], n + 16);
  endtask

  task automatic t_write();
    int n;
    @(negedge clk);
    send(1, 1'b1, 2, n);
    drain();
    check(ev_addr[2] == n, "R1 addr", ev_addr[2], n);
    check(ev_data[2] == n + 10 && ev_dwr[2] == 1'b1, "R4 data", ev_data[2], n + 10);
    check(ev_done[2] == n + 13 && ev_fwr[2] == 1'b1, "R4 done", ev_done[2], n + 13);
  endtask

  task automatic t_first_after_reset();
    int n, c0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    c0 = cyc;
    send(3, 1'b1, 3, n);
    drain();
    check(n == c0, "R7 no penalty after reset", n - c0, 0);
  endtask

  task automatic t_hold();
    int n1, n2;
    @(negedge clk);
    send(2, 1'b0, 13, n1);
    @(negedge clk);
    req_valid = 1'b1; req_bank = 2'd2; req_wr = 1'b0; req_id = 4'd14;
    #1;
    check(req_ready == 1'b0, "R8 ready low while held", int'(req_ready), 0);
    n2 = 0;
    while (!req_ready) begin @(negedge clk); #1; end
    n2 = cyc;
    @(posedge clk); #1;
    req_valid = 1'b0;
    drain();
    check(ev_addr[14] == n2 && n2 - n1 == 9, "R8 accepted when free", n2 - n1, 9);
  endtask

  initial begin
    t_reset();
    t_read();
    t_write();
    pair(2, 1'b0, 4, 2, 1'b0, 5, 9, "R5 same bank reads");
    pair(0, 1'b0, 6, 1, 1'b0, 7, 7, "R6 read read");
    pair(2, 1'b1, 8, 3, 1'b1, 9, 4, "R6 write write");
    pair(0, 1'b0, 10, 1, 1'b1, 11, 8, "R7 read to write");
    pair(2, 1'b1, 12, 3, 1'b0, 15, 5, "R7 write to read");
    t_hold();
    t_first_after_reset();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule